// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block turns the operand fields of one memory-operand instruction into the address that the load/store path will use. A request carries a mode code, a base register value, an index register value, a scale code, a signed displacement, the instruction's own literal field, the address of the following instruction, and the setup of a power-of-two ring buffer (its start address and the base-two logarithm of its length). One clock after the request is accepted, the block returns four things: the effective address; a flag that says whether the operand touches memory at all; an updated pointer value; and a write-back strobe for the two auto-increment modes.

The unit covers nine operand forms. In the immediate and direct forms the literal field is used as is. In the register-indirect form the base register is used unchanged. The other forms add things to a start value: base plus displacement; base plus scaled index plus displacement; next-instruction-relative; pre- and post-increment of the base by the displacement; and a ring-buffer form. In the ring-buffer form the offset is wrapped to the buffer length before the buffer start is added. Every sum is taken modulo 2^32 and no overflow is flagged. Mode codes that are not assigned raise an error flag and give a zero address. The register file, the memory access and address translation sit outside the block.

A valid/ready pair on each side gives one cycle of latency. A response that the consumer has not taken stays stable, and no new request is accepted while it waits.

Top module: `ea_gen`

## Requirements
- R1: Mode code 0 (immediate) returns the literal field as the address, with memory flag 0 and write-back 0.
- R2: Mode code 1 (direct) returns the literal field as the address, with memory flag 1.
- R3: Mode code 2 (register indirect) returns the base value unchanged as the address.
- R4: Mode code 3 returns base plus the 16-bit displacement sign-extended to 32 bits, modulo 2^32.
- R5: Mode code 4 returns base + index·2^s + sign-extended displacement, modulo 2^32. The 2-bit scale code s is 0, 1, 2 or 3, meaning a factor of 1, 2, 4 or 8.
- R6: Mode code 5 returns the next-instruction address plus the sign-extended displacement, modulo 2^32.
- R7: Mode code 7 (post-increment) returns the old base as the address, base + sign-extended displacement as the new pointer, and write-back 1.
- R8: Mode code 6 (pre-increment) returns base + sign-extended displacement as both the address and the new pointer, with write-back 1.
- R9: Mode code 8 (ring buffer) returns ring start + ((index + sign-extended displacement) mod 2^p). Here p is the 5-bit length logarithm, 0 to 31, and the start is added only after the wrap.
- R10: Modes 1 to 8 set the memory flag to 1. Every mode other than 6 and 7 sets write-back to 0 and returns the input base as the new pointer.
- R11: Mode codes 9 to 15 set the illegal flag to 1 and return address 0, memory flag 0 and write-back 0. Codes 0 to 8 clear the illegal flag.
- R12: A request taken while req_valid and req_ready are both high gives rsp_valid in the next cycle. While rsp_valid is high and rsp_ready is low, the response holds and req_ready is 0.
- R13: During and just after reset, rsp_valid is 0 and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_mode | input | 4 | Operand form code |
| req_base | input | 32 | Base register value |
| req_index | input | 32 | Index register value |
| req_scale | input | 2 | Index scale code (shift amount) |
| req_disp | input | 16 | Signed displacement or step |
| req_field | input | 32 | Literal field from the instruction |
| req_next_pc | input | 32 | Address of the following instruction |
| ring_base | input | 32 | Ring buffer start address |
| ring_log2 | input | 5 | Base-two logarithm of ring length |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_ea | output | 32 | Effective address |
| rsp_mem | output | 1 | Operand accesses memory |
| rsp_new_base | output | 32 | Updated pointer value |
| rsp_wb | output | 1 | Write new pointer back to the base register |
| rsp_illegal | output | 1 | Unassigned mode code |

## Verification
All sixteen mode codes are swept against base values near zero, near the top of the address space and at the sign boundary, and against displacements at both extremes of the signed range. The sign-boundary values separate sign extension from zero extension, and the near-top values show that sums wrap. The scaled form is run with every scale code and a large index, which shows whether the shift amount is right. The ring form is run with lengths from 2^0 to 2^31, with a ring start and offset chosen so that adding the start before the wrap would give a different address. A stalled consumer separates a held response from one that is overwritten.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;

  localparam int unsigned MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    M_LIT     = 4'd0,
    M_ABS     = 4'd1,
    M_REG     = 4'd2,
    M_BDISP   = 4'd3,
    M_BSIDX   = 4'd4,
    M_PCREL   = 4'd5,
    M_PREINC  = 4'd6,
    M_POSTINC = 4'd7,
    M_RING    = 4'd8
  } ea_mode_e;

  function automatic logic mode_legal(input logic [MODE_W-1:0] m);
    return (m <= M_RING);
  endfunction

  function automatic logic mode_touches_mem(input logic [MODE_W-1:0] m);
    return (m != M_LIT) && mode_legal(m);
  endfunction

  function automatic logic mode_writes_back(input logic [MODE_W-1:0] m);
    return (m == M_PREINC) || (m == M_POSTINC);
  endfunction

endpackage

// File: rtl/ea_ring_wrap.sv
module ea_ring_wrap #(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 5
) (
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] offset,
  input  logic [LW-1:0] log2_len,
  output logic [AW-1:0] wrapped_off,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] keep_mask;

  // bit g of the mask survives when g < log2_len
  for (genvar g = 0; g < AW; g++) begin : g_mask
    assign keep_mask[g] = (32'(g) < 32'(log2_len));
  end

  // the wrap is done first and the start is added after it
  assign wrapped_off = offset & keep_mask;
  assign addr        = start_addr + wrapped_off;

endmodule

// File: rtl/ea_compute.sv
module ea_compute
  import ea_gen_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 16,
  parameter int unsigned SW = 2,
  parameter int unsigned LW = 5
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [AW-1:0]     base,
  input  logic [AW-1:0]     index,
  input  logic [SW-1:0]     scale,
  input  logic [DW-1:0]     disp,
  input  logic [AW-1:0]     field,
  input  logic [AW-1:0]     next_pc,
  input  logic [AW-1:0]     rbase,
  input  logic [LW-1:0]     rlog2,
  output logic [AW-1:0]     ea,
  output logic              mem,
  output logic [AW-1:0]     new_base,
  output logic              wb,
  output logic              illegal
);

  function automatic logic [AW-1:0] sext(input logic [DW-1:0] d);
    return {{(AW-DW){d[DW-1]}}, d};
  endfunction

  function automatic logic [AW-1:0] scaled(input logic [AW-1:0] x,
                                           input logic [SW-1:0] s);
    return x << s;
  endfunction

  logic [AW-1:0] disp_x;
  logic [AW-1:0] base_step;
  logic [AW-1:0] sidx_sum;
  logic [AW-1:0] pc_sum;
  logic [AW-1:0] ring_off;
  logic [AW-1:0] ring_wrapped;
  logic [AW-1:0] ring_addr;

  assign disp_x    = sext(disp);
  assign base_step = base + disp_x;
  assign sidx_sum  = base + scaled(index, scale) + disp_x;
  assign pc_sum    = next_pc + disp_x;
  assign ring_off  = index + disp_x;

  ea_ring_wrap #(.AW(AW), .LW(LW)) u_ring (
    .start_addr (rbase),
    .offset     (ring_off),
    .log2_len   (rlog2),
    .wrapped_off(ring_wrapped),
    .addr       (ring_addr)
  );

  always_comb begin
    ea = '0;
    case (mode)
      M_LIT, M_ABS: ea = field;
      M_REG:        ea = base;
      M_BDISP:      ea = base_step;
      M_BSIDX:      ea = sidx_sum;
      M_PCREL:      ea = pc_sum;
      M_PREINC:     ea = base_step;
      M_POSTINC:    ea = base;
      M_RING:       ea = ring_addr;
      default:      ea = '0;
    endcase
  end

  assign illegal  = !mode_legal(mode);
  assign mem      = mode_touches_mem(mode);
  assign wb       = mode_writes_back(mode);
  assign new_base = wb ? base_step : base;

endmodule

// File: rtl/ea_out_reg.sv
module ea_out_reg #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_fire,
  input  logic [AW-1:0] in_ea,
  input  logic          in_mem,
  input  logic [AW-1:0] in_nb,
  input  logic          in_wb,
  input  logic          in_ill,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [AW-1:0] out_ea,
  output logic          out_mem,
  output logic [AW-1:0] out_nb,
  output logic          out_wb,
  output logic          out_ill
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_fire) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_ea  <= '0;
      out_mem <= 1'b0;
      out_nb  <= '0;
      out_wb  <= 1'b0;
      out_ill <= 1'b0;
    end else if (in_fire) begin
      out_ea  <= in_ea;
      out_mem <= in_mem;
      out_nb  <= in_nb;
      out_wb  <= in_wb;
      out_ill <= in_ill;
    end
  end

endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_gen_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 16,
  parameter int unsigned SW = 2,
  parameter int unsigned LW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [MODE_W-1:0] req_mode,
  input  logic [AW-1:0]     req_base,
  input  logic [AW-1:0]     req_index,
  input  logic [SW-1:0]     req_scale,
  input  logic [DW-1:0]     req_disp,
  input  logic [AW-1:0]     req_field,
  input  logic [AW-1:0]     req_next_pc,
  input  logic [AW-1:0]     ring_base,
  input  logic [LW-1:0]     ring_log2,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [AW-1:0]     rsp_ea,
  output logic              rsp_mem,
  output logic [AW-1:0]     rsp_new_base,
  output logic              rsp_wb,
  output logic              rsp_illegal
);

  logic          accept;
  logic [AW-1:0] c_ea;
  logic          c_mem;
  logic [AW-1:0] c_nb;
  logic          c_wb;
  logic          c_ill;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  ea_compute #(.AW(AW), .DW(DW), .SW(SW), .LW(LW)) u_comp (
    .mode    (req_mode),
    .base    (req_base),
    .index   (req_index),
    .scale   (req_scale),
    .disp    (req_disp),
    .field   (req_field),
    .next_pc (req_next_pc),
    .rbase   (ring_base),
    .rlog2   (ring_log2),
    .ea      (c_ea),
    .mem     (c_mem),
    .new_base(c_nb),
    .wb      (c_wb),
    .illegal (c_ill)
  );

  ea_out_reg #(.AW(AW)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_fire  (accept),
    .in_ea    (c_ea),
    .in_mem   (c_mem),
    .in_nb    (c_nb),
    .in_wb    (c_wb),
    .in_ill   (c_ill),
    .out_ready(rsp_ready),
    .out_valid(rsp_valid),
    .out_ea   (rsp_ea),
    .out_mem  (rsp_mem),
    .out_nb   (rsp_new_base),
    .out_wb   (rsp_wb),
    .out_ill  (rsp_illegal)
  );

endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          accept,
  input logic          req_ready,
  input logic [3:0]    req_mode,
  input logic [AW-1:0] req_base,
  input logic [AW-1:0] req_field,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [AW-1:0] rsp_ea,
  input logic          rsp_mem,
  input logic [AW-1:0] rsp_new_base,
  input logic          rsp_wb,
  input logic          rsp_illegal
);

  // R12: an accepted request is answered in the next cycle
  a_r12_latency: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);

  // R12: a stalled response holds and blocks new requests
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_ea) && $stable(rsp_new_base) && $stable(rsp_mem)));

  a_r12_block: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R1: literal mode never touches memory
  a_r1_literal: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_mode == 4'd0) |=> (!rsp_mem && rsp_ea == $past(req_field)));

  // R7: post-increment uses the old base
  a_r7_post_old: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_mode == 4'd7) |=> (rsp_ea == $past(req_base) && rsp_wb));

  // R8: pre-increment address and written pointer agree
  a_r8_pre_same: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_mode == 4'd6) |=> (rsp_ea == rsp_new_base && rsp_wb));

  // R10: other modes leave the base alone
  a_r10_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_mode != 4'd6 && req_mode != 4'd7) |=>
      (!rsp_wb && rsp_new_base == $past(req_base)));

  // R11: unassigned codes give a zero, memory-free result
  a_r11_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_illegal) |-> (rsp_ea == '0 && !rsp_mem && !rsp_wb));

endmodule

bind ea_gen ea_gen_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .accept      (accept),
  .req_ready   (req_ready),
  .req_mode    (req_mode),
  .req_base    (req_base),
  .req_field   (req_field),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_ea      (rsp_ea),
  .rsp_mem     (rsp_mem),
  .rsp_new_base(rsp_new_base),
  .rsp_wb      (rsp_wb),
  .rsp_illegal (rsp_illegal)
);

// File: tb/ea_gen_test.sv
`timescale 1ns/1ps
module ea_gen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_mode = '0;
  logic [31:0] req_base = '0, req_index = '0, req_field = '0, req_next_pc = '0;
  logic [1:0]  req_scale = '0;
  logic [15:0] req_disp = '0;
  logic [31:0] ring_base = '0;
  logic [4:0]  ring_log2 = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_ea, rsp_new_base;
  logic        rsp_mem, rsp_wb, rsp_illegal;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ea_gen uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_base(req_base), .req_index(req_index),
    .req_scale(req_scale), .req_disp(req_disp), .req_field(req_field),
    .req_next_pc(req_next_pc), .ring_base(ring_base), .ring_log2(ring_log2),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ea(rsp_ea),
    .rsp_mem(rsp_mem), .rsp_new_base(rsp_new_base), .rsp_wb(rsp_wb),
    .rsp_illegal(rsp_illegal)
  );

  localparam longint unsigned M32 = 64'h1_0000_0000;

  function automatic longint unsigned sx(input logic [15:0] d);
    longint unsigned v = longint'(d);
    if (d >= 16'h8000) v = v + M32 - 64'h1_0000;
    return v;
  endfunction

  function automatic string tag_of(input int m);
    case (m)
      0: return "R1";  1: return "R2";  2: return "R3";  3: return "R4";
      4: return "R5";  5: return "R6";  6: return "R8";  7: return "R7";
      8: return "R9";  default: return "R11";
    endcase
  endfunction

  task automatic check1(input string tag, input string what,
                        input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic run_one(input int m, input logic [31:0] b, input logic [31:0] ix,
                         input logic [1:0] sc, input logic [15:0] d,
                         input logic [31:0] f, input logic [31:0] pc,
                         input logic [31:0] rb, input logic [4:0] p);
    longint unsigned e_ea, e_nb, step, off;
    logic e_mem, e_wb, e_ill;
    string t;
    t = tag_of(m);
    step = (longint'(b) + sx(d)) % M32;
    e_nb = longint'(b); e_wb = 0; e_ill = 0; e_mem = 1;
    case (m)
      0: begin e_ea = longint'(f); e_mem = 0; end
      1: e_ea = longint'(f);
      2: e_ea = longint'(b);
      3: e_ea = step;
      4: e_ea = (longint'(b) + longint'(ix) * (64'd1 << sc) + sx(d)) % M32;
      5: e_ea = (longint'(pc) + sx(d)) % M32;
      6: begin e_ea = step; e_nb = step; e_wb = 1; end
      7: begin e_ea = longint'(b); e_nb = step; e_wb = 1; end
      8: begin
           off  = ((longint'(ix) + sx(d)) % M32) % (64'd1 << p);
           e_ea = (longint'(rb) + off) % M32;
         end
      default: begin e_ea = 0; e_mem = 0; e_ill = 1; end
    endcase
    @(negedge clk);
    req_mode = 4'(m); req_base = b; req_index = ix; req_scale = sc; req_disp = d;
    req_field = f; req_next_pc = pc; ring_base = rb; ring_log2 = p;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check1(t, "ea", longint'(rsp_ea), e_ea);
    // R10 memory flag, write-back and pointer for every mode
    check1((m == 6 || m == 7) ? t : "R10", "mem", longint'(rsp_mem), longint'(e_mem));
    check1((m == 6 || m == 7) ? t : "R10", "wb", longint'(rsp_wb), longint'(e_wb));
    check1((m == 6 || m == 7) ? t : "R10", "new_base", longint'(rsp_new_base), e_nb);
    check1("R11", "illegal", longint'(rsp_illegal), longint'(e_ill));
    check1("R12", "valid", longint'(rsp_valid), 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  logic [31:0] bases [4] = '{32'h0000_0000, 32'hFFFF_FFF0, 32'h1234_5678, 32'h7FFF_FFFC};
  logic [15:0] disps [4] = '{16'h0000, 16'h7FFF, 16'h8000, 16'hFFFC};
  logic [4:0]  lens  [6] = '{5'd0, 5'd1, 5'd4, 5'd8, 5'd16, 5'd31};

  initial begin
    logic [31:0] first_ea;
    // R13 reset state
    repeat (3) @(negedge clk);
    check1("R13", "valid in reset", longint'(rsp_valid), 0);
    check1("R13", "ready in reset", longint'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check1("R13", "valid after reset", longint'(rsp_valid), 0);

    for (int m = 0; m < 16; m++)
      for (int bi = 0; bi < 4; bi++)
        for (int di = 0; di < 4; di++)
          run_one(m, bases[bi], 32'hC000_0011 ^ bases[bi], 2'd1, disps[di],
                  32'hA5A5_0000 + 32'(m), 32'hFFFF_FF00 + 32'(bi), 32'h0000_1000, 5'd4);

    // R5 every scale code
    for (int sc = 0; sc < 4; sc++)
      for (int di = 0; di < 4; di++)
        run_one(4, 32'h1000_0000, 32'h3FFF_FFFF, 2'(sc), disps[di], 0, 0, 0, 0);

    // R9 every listed length, start added after wrap
    for (int li = 0; li < 6; li++)
      for (int di = 0; di < 4; di++)
        run_one(8, 32'h5555_5555, 32'h0000_0FF7 + 32'(li), 2'd3, disps[di],
                0, 0, 32'hF000_0F00, lens[li]);

    // R12 back-pressure: response held, req_ready low
    @(negedge clk);
    rsp_ready = 1'b0;
    req_mode = 4'd2; req_base = 32'h0000_0ABC; req_valid = 1'b1;
    @(negedge clk);
    first_ea = rsp_ea;
    check1("R12", "stall ea", longint'(rsp_ea), 64'h0000_0ABC);
    check1("R12", "stall ready", longint'(req_ready), 0);
    req_base = 32'h0000_0DEF;
    @(negedge clk);
    check1("R12", "held ea", longint'(rsp_ea), longint'(first_ea));
    check1("R12", "held valid", longint'(rsp_valid), 1);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check1("R12", "next ea", longint'(rsp_ea), 64'h0000_0DEF);
    @(negedge clk);
    check1("R12", "drained", longint'(rsp_valid), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule